// File: doc/BRIEF.md
# Serial Line Loss-of-Signal Detector

This block watches a bipolar received line, given as two pulse rails, and decides whether the incoming signal has been lost. A bit counts as a one when either rail carries a pulse. Loss is entered after a long unbroken run of zeros, or at once while an external loss input from the line interface is high. Loss is left only when the density of ones in a sliding window of recent bits is high enough. The two rules differ on purpose, so that a marginal line does not flip the status back and forth.

Bits are taken only on cycles where a bit-valid strobe is high. The external loss input is looked at on every cycle. The outputs are a loss level and a one-cycle change strobe that pulses on entry to and exit from loss. Two request lines follow the loss level: one asks the framer to go out of frame, and the other asks the transmitter to send a far-end receive failure indication. All outputs are registered.

The run length, window length and ones threshold are parameters, with defaults of 180, 180 and 60.

Top module: `los_detector`

## Requirements
- R1: A received bit is a one when `rx_pos_i` or `rx_neg_i` is high (either or both) on a bit-valid cycle, and a zero when both are low.
- R2: After reset `loss_o`, `oof_req_o` and `ferf_req_o` are 1 and `loss_chg_o` is 0. The zero-run count and the ones window start cleared.
- R3: With `zero_det_en_i` = 1, loss is declared on the bit that completes `RUN_LEN` consecutive zeros. `RUN_LEN`-1 zeros do not declare it.
- R4: Any received one restarts the zero run from 0. The run count saturates at `RUN_LEN`.
- R5: With `zero_det_en_i` = 0, no run of zeros declares loss. If the input is set to 1 again once the run has already reached `RUN_LEN`, the next zero bit declares loss.
- R6: While `ext_loss_i` is high, loss is set on the next cycle and stays set, whatever the bit history. Loss cannot clear while it is high.
- R7: While loss is set, it clears on a bit where at least `MIN_ONES` of the last `WIN_LEN` received bits (including that bit) are ones. `MIN_ONES`-1 ones are not enough.
- R8: Ones that have left the `WIN_LEN`-bit window no longer count. A steady density below `MIN_ONES` per window never clears loss.
- R9: `loss_chg_o` is high for exactly one cycle on each change of `loss_o`, in both directions, and is low otherwise.
- R10: `oof_req_o` and `ferf_req_o` equal `loss_o` on every cycle.
- R11: Cycles with `bit_valid_i` low change neither the zero run nor the window. With `ext_loss_i` low, they do not change `loss_o`.
- R12: Every output changes on the clock edge that samples the deciding bit, or the edge that samples `ext_loss_i`, and on no later edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bit_valid_i | input | 1 | A received bit is present on the rails this cycle |
| rx_pos_i | input | 1 | Positive pulse rail |
| rx_neg_i | input | 1 | Negative pulse rail |
| ext_loss_i | input | 1 | External loss indication from the line interface |
| zero_det_en_i | input | 1 | Enables the zero-run declare rule |
| loss_o | output | 1 | Loss-of-signal level |
| loss_chg_o | output | 1 | One-cycle strobe on each change of loss |
| oof_req_o | output | 1 | Request to declare out of frame |
| ferf_req_o | output | 1 | Request to send a far-end receive failure indication |

## Verification
Every output is due on the rising edge that samples the deciding bit or the `ext_loss_i` level. There is no added latency, so the change strobe is high for only that one cycle. The bench drives inputs on the falling edge. It checks all four outputs 2 ns after the next rising edge, against a model that keeps the last `WIN_LEN` bits in a plain array and counts their ones afresh on every bit. Directed phases place the 59th/60th one and the 179th/180th zero on known bits, so each boundary is checked on the exact cycle it is crossed. A long pseudo-random sweep then mixes valid gaps, rail patterns, the enable and external loss pulses.

// File: rtl/los_pkg.sv
package los_pkg;

   typedef enum logic {
      LOS_CLEAR  = 1'b0,
      LOS_ACTIVE = 1'b1
   } los_state_e;

endpackage

// File: rtl/los_zero_run.sv
module los_zero_run #(
   parameter int RUN_LEN = 180,
   localparam int CW     = $clog2(RUN_LEN + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bit_valid_i,
   input  logic          bit_i,
   output logic [CW-1:0] run_nxt_o
);

   localparam logic [CW-1:0] RUN_MAX = CW'(RUN_LEN);

   logic [CW-1:0] run_q;

   always_comb begin
      run_nxt_o = run_q;
      if (bit_valid_i) begin
         if (bit_i)
            run_nxt_o = '0;
         else if (run_q != RUN_MAX)
            run_nxt_o = run_q + 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) run_q <= '0;
      else        run_q <= run_nxt_o;
   end

   AST_RUN_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
      run_q <= RUN_MAX); // R4
   AST_ONE_RESTARTS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
      (bit_valid_i && bit_i) |=> (run_q == '0)); // R4
   AST_RUN_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_valid_i |=> $stable(run_q)); // R11

endmodule

// File: rtl/los_ones_window.sv
module los_ones_window #(
   parameter int WIN_LEN = 180,
   localparam int CW     = $clog2(WIN_LEN + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          bit_valid_i,
   input  logic          bit_i,
   output logic [CW-1:0] ones_nxt_o
);

   logic [WIN_LEN-1:0] hist_q;
   logic [CW-1:0]      ones_q;
   logic               oldest;

   assign oldest = hist_q[WIN_LEN-1];

   generate
      if (WIN_LEN == 1) begin : g_single
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)           hist_q <= '0;
            else if (bit_valid_i) hist_q <= bit_i;
         end
      end else begin : g_shift
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)           hist_q <= '0;
            else if (bit_valid_i) hist_q <= {hist_q[WIN_LEN-2:0], bit_i};
         end
      end
   endgenerate

   always_comb begin
      ones_nxt_o = ones_q;
      if (bit_valid_i) begin
         case ({bit_i, oldest})
            2'b10:   ones_nxt_o = ones_q + 1'b1;
            2'b01:   ones_nxt_o = ones_q - 1'b1;
            default: ones_nxt_o = ones_q;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) ones_q <= '0;
      else        ones_q <= ones_nxt_o;
   end

   AST_ONES_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      ones_q <= CW'(WIN_LEN)); // R8
   AST_WINDOW_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
      ones_q == CW'($countones(hist_q))); // R8
   AST_WINDOW_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !bit_valid_i |=> ($stable(ones_q) && $stable(hist_q))); // R11

endmodule

// File: rtl/los_detector.sv
module los_detector #(
   parameter int RUN_LEN  = 180,
   parameter int WIN_LEN  = 180,
   parameter int MIN_ONES = 60
) (
   input  logic clk,
   input  logic rst_n,
   input  logic bit_valid_i,
   input  logic rx_pos_i,
   input  logic rx_neg_i,
   input  logic ext_loss_i,
   input  logic zero_det_en_i,
   output logic loss_o,
   output logic loss_chg_o,
   output logic oof_req_o,
   output logic ferf_req_o
);
   import los_pkg::*;

   localparam int RCW = $clog2(RUN_LEN + 1);
   localparam int OCW = $clog2(WIN_LEN + 1);
   localparam logic [RCW-1:0] RUN_MAX  = RCW'(RUN_LEN);
   localparam logic [OCW-1:0] ONES_MIN = OCW'(MIN_ONES);

   generate
      if (RUN_LEN < 1) begin : g_bad_run
         $error("RUN_LEN must be at least 1");
      end
      if (WIN_LEN < 1) begin : g_bad_win
         $error("WIN_LEN must be at least 1");
      end
      if (MIN_ONES < 1 || MIN_ONES > WIN_LEN) begin : g_bad_ones
         $error("MIN_ONES must lie in 1..WIN_LEN");
      end
   endgenerate

   logic           rx_bit;
   logic [RCW-1:0] run_nxt;
   logic [OCW-1:0] ones_nxt;
   los_state_e     loss_q, loss_d;
   logic           chg_q;

   assign rx_bit = rx_pos_i | rx_neg_i;

   los_zero_run #(.RUN_LEN(RUN_LEN)) u_run (
      .clk         (clk),
      .rst_n       (rst_n),
      .bit_valid_i (bit_valid_i),
      .bit_i       (rx_bit),
      .run_nxt_o   (run_nxt)
   );

   los_ones_window #(.WIN_LEN(WIN_LEN)) u_win (
      .clk         (clk),
      .rst_n       (rst_n),
      .bit_valid_i (bit_valid_i),
      .bit_i       (rx_bit),
      .ones_nxt_o  (ones_nxt)
   );

   always_comb begin
      loss_d = loss_q;
      if (ext_loss_i)
         loss_d = LOS_ACTIVE;
      else if (bit_valid_i) begin
         if (loss_q == LOS_CLEAR && zero_det_en_i && run_nxt == RUN_MAX)
            loss_d = LOS_ACTIVE;
         else if (loss_q == LOS_ACTIVE && ones_nxt >= ONES_MIN)
            loss_d = LOS_CLEAR;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         loss_q <= LOS_ACTIVE;
         chg_q  <= 1'b0;
      end else begin
         loss_q <= loss_d;
         chg_q  <= (loss_d != loss_q);
      end
   end

   assign loss_o     = (loss_q == LOS_ACTIVE);
   assign loss_chg_o = chg_q;
   assign oof_req_o  = loss_o;
   assign ferf_req_o = loss_o;

   AST_EXT_FORCES_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
      ext_loss_i |=> loss_o); // R6
   AST_STROBE_ON_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
      chg_q |-> (loss_q != $past(loss_q))); // R9
   AST_CHANGE_HAS_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      (loss_q != $past(loss_q)) |-> chg_q); // R9
   AST_IDLE_HOLDS_LOSS: assert property (@(posedge clk) disable iff (!rst_n)
      (!bit_valid_i && !ext_loss_i) |=> $stable(loss_q)); // R11
   AST_NO_ZERO_DECLARE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      (!zero_det_en_i && !ext_loss_i && !loss_o) |=> !loss_o); // R5

endmodule

// File: tb/los_detector_test.sv
module los_detector_test;

   localparam int RUN  = 180;
   localparam int WIN  = 180;
   localparam int MINO = 60;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bit_valid_i = 1'b0, rx_pos_i = 1'b0, rx_neg_i = 1'b0;
   logic ext_loss_i = 1'b0, zero_det_en_i = 1'b1;
   logic loss_o, loss_chg_o, oof_req_o, ferf_req_o;

   int n_checks = 0;
   int n_fails  = 0;

   int  m_hist [WIN];
   int  m_ptr  = 0;
   int  m_run  = 0;
   logic m_loss = 1'b1;
   logic m_chg  = 1'b0;

   always #4 clk = ~clk;

   los_detector #(.RUN_LEN(RUN), .WIN_LEN(WIN), .MIN_ONES(MINO)) uut (
      .clk(clk), .rst_n(rst_n), .bit_valid_i(bit_valid_i),
      .rx_pos_i(rx_pos_i), .rx_neg_i(rx_neg_i), .ext_loss_i(ext_loss_i),
      .zero_det_en_i(zero_det_en_i), .loss_o(loss_o), .loss_chg_o(loss_chg_o),
      .oof_req_o(oof_req_o), .ferf_req_o(ferf_req_o)
   );

   task automatic chk(input string tag, input string what, input logic got, input logic exp);
      n_checks++;
      if (got !== exp) begin
         n_fails++;
         $display("FAIL %s %s: actual %b expected %b at %0t", tag, what, got, exp, $time);
      end
   endtask

   function automatic int win_ones();
      int s = 0;
      for (int i = 0; i < WIN; i++) s += m_hist[i];
      return s;
   endfunction

   // one clock: drive on the falling edge, check 2 ns after the rising edge
   task automatic step(input logic v, input logic p, input logic n, input logic x,
                       input logic e, input string tag);
      logic b, prev;
      @(negedge clk);
      bit_valid_i = v; rx_pos_i = p; rx_neg_i = n; ext_loss_i = x; zero_det_en_i = e;
      @(posedge clk);
      prev = m_loss;
      b = p | n;
      if (v) begin
         m_hist[m_ptr] = int'(b);
         m_ptr = (m_ptr + 1) % WIN;
         m_run = b ? 0 : ((m_run < RUN) ? m_run + 1 : RUN);
      end
      if (x) m_loss = 1'b1;
      else if (v) begin
         if (!m_loss && e && m_run >= RUN) m_loss = 1'b1;
         else if (m_loss && win_ones() >= MINO) m_loss = 1'b0;
      end
      m_chg = (m_loss != prev);
      #2;
      chk(tag, "loss_o", loss_o, m_loss);
      chk(tag, "loss_chg_o R9", loss_chg_o, m_chg);
      chk(tag, "oof_req_o R10", oof_req_o, m_loss);
      chk(tag, "ferf_req_o R10", ferf_req_o, m_loss);
   endtask

   task automatic ones_n(input int cnt, input string tag);
      for (int i = 0; i < cnt; i++) step(1, 1, 0, 0, 1, tag);
   endtask

   task automatic zeros_n(input int cnt, input string tag);
      for (int i = 0; i < cnt; i++) step(1, 0, 0, 0, 1, tag);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

   initial begin
      logic [15:0] lfsr;
      for (int i = 0; i < WIN; i++) m_hist[i] = 0;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R2: reset state
      chk("R2", "loss_o", loss_o, 1'b1);
      chk("R2", "loss_chg_o", loss_chg_o, 1'b0);
      chk("R2", "oof_req_o", oof_req_o, 1'b1);
      chk("R2", "ferf_req_o", ferf_req_o, 1'b1);

      // R1: pos-only, neg-only and both-rail ones all count; clears on the 60th
      for (int i = 0; i < 20; i++) step(1, 1, 0, 0, 1, "R1");
      for (int i = 0; i < 20; i++) step(1, 0, 1, 0, 1, "R1");
      for (int i = 0; i < 19; i++) step(1, 1, 1, 0, 1, "R1");
      chk("R7", "loss_o before 60th one", loss_o, 1'b1);
      step(1, 1, 1, 0, 1, "R7");
      chk("R7", "loss_o after 60th one", loss_o, 1'b0);
      chk("R12", "strobe on clearing edge", loss_chg_o, 1'b1);
      step(0, 0, 0, 0, 1, "R9");
      chk("R9", "strobe one cycle only", loss_chg_o, 1'b0);

      // R3: 179 zeros keep clear, 180th declares
      zeros_n(RUN - 1, "R3");
      chk("R3", "loss_o after 179 zeros", loss_o, 1'b0);
      zeros_n(1, "R3");
      chk("R3", "loss_o after 180 zeros", loss_o, 1'b1);
      chk("R9", "strobe on entry", loss_chg_o, 1'b1);

      // R7: window now all zeros; 59 ones then zeros are not enough
      ones_n(MINO - 1, "R7");
      zeros_n(5, "R7");
      chk("R7", "loss_o with 59 ones", loss_o, 1'b1);
      ones_n(1, "R7");
      chk("R7", "loss_o with 60 ones", loss_o, 1'b0);

      // R4: a single one restarts the zero run
      zeros_n(RUN - 1, "R4");
      ones_n(1, "R4");
      zeros_n(RUN - 1, "R4");
      chk("R4", "loss_o after broken run", loss_o, 1'b0);
      zeros_n(1, "R4");
      chk("R4", "loss_o after full run", loss_o, 1'b1);

      // R5: enable off, long zero run; enable back on, next zero declares
      ones_n(MINO, "R5");
      chk("R5", "loss_o cleared", loss_o, 1'b0);
      for (int i = 0; i < 2 * RUN; i++) step(1, 0, 0, 0, 0, "R5");
      chk("R5", "loss_o with rule off", loss_o, 1'b0);
      step(1, 0, 0, 0, 1, "R5");
      chk("R5", "loss_o when rule back on", loss_o, 1'b1);

      // R8: one in four never clears; one in three clears
      for (int i = 0; i < 4 * WIN; i++) step(1, (i % 4) == 0, 0, 0, 1, "R8");
      chk("R8", "loss_o at 1/4 density", loss_o, 1'b1);
      for (int i = 0; i < 2 * WIN; i++) step(1, (i % 3) == 0, 0, 0, 1, "R8");
      chk("R8", "loss_o at 1/3 density", loss_o, 1'b0);

      // R6: external loss overrides, blocks clearing; R11: idle cycles hold
      ones_n(WIN, "R6");
      step(0, 0, 0, 1, 1, "R6");
      chk("R6", "loss_o forced", loss_o, 1'b1);
      for (int i = 0; i < 30; i++) step(1, 1, 0, 1, 1, "R6");
      chk("R6", "loss_o held by pin", loss_o, 1'b1);
      for (int i = 0; i < 10; i++) step(0, 1, 1, 0, 1, "R11");
      chk("R11", "loss_o idle after pin drop", loss_o, 1'b1);
      step(1, 1, 0, 0, 1, "R11");
      chk("R11", "loss_o clears on next bit", loss_o, 1'b0);
      for (int i = 0; i < 2 * RUN; i++) step(0, 0, 0, 0, 1, "R11");
      chk("R11", "loss_o after idle zeros", loss_o, 1'b0);

      // R12: pseudo-random sweep against the model
      lfsr = 16'hACE1;
      for (int i = 0; i < 6000; i++) begin
         logic v, p, n, x, e;
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         v = (lfsr[2:0] != 3'd0);
         p = (lfsr[6:4] == 3'd0) && lfsr[8];
         n = (lfsr[6:4] == 3'd0) && !lfsr[8] || (lfsr[11:9] == 3'd7);
         x = (lfsr[15:9] == 7'd0);
         e = (lfsr[14:12] != 3'd0);
         if (i >= 3000) begin
            p = lfsr[5] & lfsr[7];
            n = lfsr[9] & lfsr[3] & lfsr[6];
         end
         step(v, p, n, x, e, "R12");
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
   end

endmodule